// File: doc/BRIEF.md
# Multi-Channel Compare Timer

This block is a memory-mapped up-counting timer. A three-bit source selector in the control word picks one of several tick-enable inputs, and a twelve-bit divider thins those ticks before they reach the counter. The counter value is compared against three compare registers. Each compare match, and each wrap of the counter past its all-ones value, latches a status flag. A level interrupt is raised whenever a latched flag is also enabled and the timer is running.

There are two counting modes. In restart mode, compare register 1 sets the period: the counter returns to zero on the tick after it equals that register, and writing that register restarts the count. In free-running mode, the counter runs through its full range and wraps. A control write that has the software-reset bit set performs a soft reset. It keeps a small set of control bits from the written word and returns every other register to its reset value.

The register bus is word-addressed and plain. A write takes effect at the clock edge on which the write strobe is high. Read data follows the address combinationally. The bus has no handshake and never stalls, so back-pressure does not apply. The tick inputs are sampled once per clock.

Top module: `cmp_timer`

## Requirements
- R1: Reads at word address 0 return control, 1 the divider, 2 status, 3 interrupt enable, 4 to 6 compare 1 to 3, and 9 the counter. The capture addresses 7 and 8, and every unmapped address, read as zero.
- R2: Control bits 8:6 choose the clock source. Code 0 never advances the counter. Code k (1 to 7) uses tick input bit k.
- R3: The divider register keeps the low 12 bits of a write. The counter advances once per (divider + 1) selected ticks, and the divide phase restarts on each divider write.
- R4: Clearing control bit 0 (enable) freezes the counter. When bit 0 goes from 0 to 1 with bit 1 set, the counter restarts at 0. With bit 1 clear, counting resumes from the held value.
- R5: In restart mode (control bit 9 clear), a tick that finds the counter equal to compare 1 loads 0 instead of incrementing, and no rollover flag is set.
- R6: In restart mode, a write to compare 1 clears the counter. In free-running mode, the same write leaves the counter unchanged.
- R7: In free-running mode (bit 9 set), a tick at the all-ones count wraps the counter to 0 and sets status bit 5.
- R8: Status bits 0, 1 and 2 are set on the tick at which the counter takes the value of compare 1, 2 or 3, whatever the interrupt-enable bits are.
- R9: Writing ones to status bits 5:0 clears those bits, and a flag set in the same cycle wins over the clear. The interrupt-enable register keeps only bits 5:0. Status bits 3 and 4 are never set.
- R10: The interrupt output is high exactly when the status register ANDed with the interrupt-enable register is nonzero and control bit 0 is set.
- R11: Control bits in mask 0x7C14 are never stored and read back as 0.
- R12: A control write with bit 15 set is a soft reset. It keeps only bits 0, 1, 3, 5 and 8:6 of the written word, sets all compare registers to all ones, and clears the divider, status, interrupt enable and counter.
- R13: After a hard reset, control, divider, status, interrupt enable and the counter are 0, all compare registers are all ones, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| src_tick | input | 2**SRC_W | One tick-enable per clock source code |
| irq | output | 1 | Level interrupt |

## Verification
Several properties are checked on every cycle: the counter holds still on any cycle without an advance or a forced clear, and a restart match or a wrap lands on zero. A clock-source code of 0 never produces an advance, status bits 3 and 4 stay clear, and the interrupt stays low when no enabled flag is pending. A soft reset and a compare-1 write in restart mode are followed by the cleared state. The divide ratio, resume versus restart on enable, flag latching at the exact match tick, write-one-to-clear, the control read-back mask and the full-range wrap depend on sequences of register writes and tick counts, so only the bench scenarios can show them.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  // control word bit positions
  localparam int CB_EN      = 0;
  localparam int CB_RESTART = 1;
  localparam int CB_SRC_LO  = 6;
  localparam int CB_FREE    = 9;
  localparam int CB_SWRST   = 15;

  localparam logic [31:0] CTRL_DROP = 32'h0000_7C14;
  localparam logic [31:0] CTRL_KEEP = 32'h0000_01EB;

  // status layout
  localparam int NUM_CMP = 3;
  localparam int ST_W    = 6;
  localparam int ST_ROLL = 5;

  typedef enum logic [3:0] {
    A_CTRL = 4'd0,
    A_DIV  = 4'd1,
    A_STAT = 4'd2,
    A_IEN  = 4'd3,
    A_CMP0 = 4'd4,
    A_CMP1 = 4'd5,
    A_CMP2 = 4'd6,
    A_CAP0 = 4'd7,
    A_CAP1 = 4'd8,
    A_CNT  = 4'd9
  } reg_addr_e;

endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int PSC_W = 12,
  parameter int SRC_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  clr,
  input  logic [SRC_W-1:0]      sel,
  input  logic [(1<<SRC_W)-1:0] src_tick,
  input  logic [PSC_W-1:0]      div,
  output logic                  tick
);
  logic [PSC_W-1:0] acc_q;
  logic             src_hit;

  assign src_hit = (sel != '0) && src_tick[sel];
  assign tick    = run && src_hit && (acc_q == div) && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                acc_q <= '0;
    else if (clr)              acc_q <= '0;
    else if (run && src_hit)   acc_q <= (acc_q == div) ? '0 : acc_q + 1'b1;
  end

  // R2
  no_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> !tick);

  // R3
  div_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (acc_q == '0));
endmodule

// File: rtl/ct_compare.sv
module ct_compare #(
  parameter int W = 32
) (
  input  logic         adv,
  input  logic [W-1:0] cnt_next,
  input  logic [W-1:0] cmp_val,
  output logic         hit
);
  assign hit = adv && (cnt_next == cmp_val);
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         free_run,
  input  logic         zero,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_next,
  output logic         roll
);
  logic period_hit;

  assign period_hit = !free_run && (cnt == period);
  assign cnt_next   = period_hit ? '0 : cnt + 1'b1;
  assign roll       = adv && !period_hit && (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (zero) cnt <= '0;
    else if (adv)  cnt <= cnt_next;
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !zero) |=> $stable(cnt));

  // R5
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !free_run && (cnt == period)) |=> (cnt == '0));

  // R7
  roll_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> (cnt == '0));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 12,
  parameter int SRC_W  = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [(1<<SRC_W)-1:0] src_tick,
  output logic                  irq
);
  localparam logic [DATA_W-1:0] DROP_M = DATA_W'(CTRL_DROP);
  localparam logic [DATA_W-1:0] KEEP_M = DATA_W'(CTRL_KEEP);

  logic [DATA_W-1:0] ctrl_q, ctrl_new;
  logic [PSC_W-1:0]  div_q;
  logic [ST_W-1:0]   stat_q, stat_set;
  logic [ST_W-1:0]   ien_q;
  logic [CNT_W-1:0]  cmp_q [NUM_CMP];
  logic [NUM_CMP-1:0] cmp_hit;
  logic [NUM_CMP-1:0] cmp_wr;

  logic ctrl_wr, soft_rst, en_rise, zero_req, psc_tick, adv, roll;
  logic [CNT_W-1:0] cnt_q, cnt_next;

  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign ctrl_new = bus_wdata & ~DROP_M;
  assign soft_rst = ctrl_wr && bus_wdata[CB_SWRST];
  assign en_rise  = ctrl_wr && !soft_rst && !ctrl_q[CB_EN] && ctrl_new[CB_EN];
  assign zero_req = soft_rst
                 || (en_rise && ctrl_new[CB_RESTART])
                 || (cmp_wr[0] && !ctrl_q[CB_FREE]);
  assign adv      = psc_tick && !zero_req;

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (soft_rst) ctrl_q <= ctrl_new & KEEP_M;
    else if (ctrl_wr)  ctrl_q <= ctrl_new;
  end

  // divider and interrupt-enable registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ien_q <= '0;
    end else if (soft_rst) begin
      div_q <= '0;
      ien_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(A_DIV)) div_q <= bus_wdata[PSC_W-1:0];
      if (bus_addr == ADDR_W'(A_IEN)) ien_q <= bus_wdata[ST_W-1:0];
    end
  end

  // compare registers and match logic
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign cmp_wr[i] = bus_wr && (bus_addr == ADDR_W'(int'(A_CMP0) + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cmp_q[i] <= '1;
      else if (soft_rst)  cmp_q[i] <= '1;
      else if (cmp_wr[i]) cmp_q[i] <= bus_wdata[CNT_W-1:0];
    end

    ct_compare #(.W(CNT_W)) u_cmp (
      .adv      (adv),
      .cnt_next (cnt_next),
      .cmp_val  (cmp_q[i]),
      .hit      (cmp_hit[i])
    );
  end

  always_comb begin
    stat_set = '0;
    stat_set[NUM_CMP-1:0] = cmp_hit;
    stat_set[ST_ROLL]     = roll;
  end

  // status: write-one-to-clear, set wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stat_q <= '0;
    else if (soft_rst) stat_q <= '0;
    else if (bus_wr && (bus_addr == ADDR_W'(A_STAT)))
      stat_q <= (stat_q & ~bus_wdata[ST_W-1:0]) | stat_set;
    else
      stat_q <= stat_q | stat_set;
  end

  ct_prescaler #(.PSC_W(PSC_W), .SRC_W(SRC_W)) u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q[CB_EN]),
    .clr      (zero_req || (bus_wr && (bus_addr == ADDR_W'(A_DIV)))),
    .sel      (ctrl_q[CB_SRC_LO +: SRC_W]),
    .src_tick (src_tick),
    .div      (div_q),
    .tick     (psc_tick)
  );

  ct_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .free_run (ctrl_q[CB_FREE]),
    .zero     (zero_req),
    .period   (cmp_q[0]),
    .cnt      (cnt_q),
    .cnt_next (cnt_next),
    .roll     (roll)
  );

  assign irq = ctrl_q[CB_EN] && |(stat_q & ien_q);

  always_comb begin
    case (bus_addr)
      ADDR_W'(A_CTRL): bus_rdata = ctrl_q;
      ADDR_W'(A_DIV):  bus_rdata = DATA_W'(div_q);
      ADDR_W'(A_STAT): bus_rdata = DATA_W'(stat_q);
      ADDR_W'(A_IEN):  bus_rdata = DATA_W'(ien_q);
      ADDR_W'(A_CMP0): bus_rdata = DATA_W'(cmp_q[0]);
      ADDR_W'(A_CMP1): bus_rdata = DATA_W'(cmp_q[1]);
      ADDR_W'(A_CMP2): bus_rdata = DATA_W'(cmp_q[2]);
      ADDR_W'(A_CNT):  bus_rdata = DATA_W'(cnt_q);
      default:         bus_rdata = '0;
    endcase
  end

  // R9
  cap_flags_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[4:3] == 2'b00);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ien_q) == '0) |-> !irq);

  // R12
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (stat_q == '0 && ien_q == '0 && div_q == '0 && cnt_q == '0
                  && cmp_q[1] == '1));

  // R6
  period_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr[0] && !ctrl_q[CB_FREE]) |=> (cnt_q == '0));
endmodule

// File: tb/cmp_timer_tb_top.sv
module cmp_timer_tb_top;
  localparam int CW = 16;
  localparam int NV = 53;
  // entry: op[77:76] addr[75:72] data[71:40] exp[39:8] req[7:0]
  // op 0 write, 1 read-check, 2 run ticks, 3 irq-check
  localparam logic [77:0] VEC [NV] = '{
    {2'd0, 4'd0, 32'h41,       32'h0,  8'd4},  // R4 enable, src 1
    {2'd2, 4'd0, 32'd5,        32'h0,  8'd2},
    {2'd1, 4'd9, 32'h0,        32'd5,  8'd2},  // R2
    {2'd0, 4'd0, 32'h01,       32'h0,  8'd2},  // R2 source 0
    {2'd2, 4'd0, 32'd4,        32'h0,  8'd2},
    {2'd1, 4'd9, 32'h0,        32'd5,  8'd2},  // R2 no advance
    {2'd0, 4'd0, 32'h81,       32'h0,  8'd2},
    {2'd0, 4'd1, 32'h1002,     32'h0,  8'd3},
    {2'd1, 4'd1, 32'h0,        32'h2,  8'd3},  // R3 12 bits
    {2'd2, 4'd0, 32'd9,        32'h0,  8'd3},
    {2'd1, 4'd9, 32'h0,        32'd8,  8'd3},  // R3 divide by 3
    {2'd0, 4'd1, 32'h0,        32'h0,  8'd3},
    {2'd0, 4'd4, 32'd10,       32'h0,  8'd6},  // R6 restart mode
    {2'd1, 4'd9, 32'h0,        32'd0,  8'd6},
    {2'd2, 4'd0, 32'd10,       32'h0,  8'd8},
    {2'd1, 4'd9, 32'h0,        32'd10, 8'd8},
    {2'd1, 4'd2, 32'h0,        32'h1,  8'd8},  // R8
    {2'd2, 4'd0, 32'd1,        32'h0,  8'd5},
    {2'd1, 4'd9, 32'h0,        32'd0,  8'd5},  // R5
    {2'd2, 4'd0, 32'd3,        32'h0,  8'd5},
    {2'd1, 4'd9, 32'h0,        32'd3,  8'd5},
    {2'd0, 4'd2, 32'h3E,       32'h0,  8'd9},
    {2'd1, 4'd2, 32'h0,        32'h1,  8'd9},  // R9
    {2'd0, 4'd2, 32'h01,       32'h0,  8'd9},
    {2'd1, 4'd2, 32'h0,        32'h0,  8'd9},
    {2'd0, 4'd3, 32'hFFFFFFFF, 32'h0,  8'd9},
    {2'd1, 4'd3, 32'h0,        32'h3F, 8'd9},  // R9
    {2'd0, 4'd3, 32'h0,        32'h0,  8'd9},
    {2'd0, 4'd0, 32'h80,       32'h0,  8'd4},  // R4 disable
    {2'd2, 4'd0, 32'd6,        32'h0,  8'd4},
    {2'd1, 4'd9, 32'h0,        32'd3,  8'd4},
    {2'd0, 4'd0, 32'h81,       32'h0,  8'd4},
    {2'd2, 4'd0, 32'd2,        32'h0,  8'd4},
    {2'd1, 4'd9, 32'h0,        32'd5,  8'd4},  // R4 resume
    {2'd0, 4'd0, 32'h80,       32'h0,  8'd4},
    {2'd0, 4'd0, 32'h83,       32'h0,  8'd4},
    {2'd1, 4'd9, 32'h0,        32'd0,  8'd4},  // R4 restart
    {2'd0, 4'd0, 32'h283,      32'h0,  8'd6},  // free-run
    {2'd2, 4'd0, 32'd4,        32'h0,  8'd6},
    {2'd0, 4'd4, 32'd20,       32'h0,  8'd6},
    {2'd1, 4'd9, 32'h0,        32'd4,  8'd6},  // R6 no reset
    {2'd0, 4'd5, 32'd6,        32'h0,  8'd8},
    {2'd2, 4'd0, 32'd2,        32'h0,  8'd8},
    {2'd1, 4'd2, 32'h0,        32'h2,  8'd8},  // R8 compare 2
    {2'd3, 4'd0, 32'h0,        32'd0,  8'd10},
    {2'd0, 4'd3, 32'h02,       32'h0,  8'd10},
    {2'd3, 4'd0, 32'h0,        32'd1,  8'd10}, // R10
    {2'd0, 4'd0, 32'h282,      32'h0,  8'd10},
    {2'd3, 4'd0, 32'h0,        32'd0,  8'd10},
    {2'd0, 4'd0, 32'h283,      32'h0,  8'd10},
    {2'd3, 4'd0, 32'h0,        32'd1,  8'd10},
    {2'd0, 4'd2, 32'h02,       32'h0,  8'd10},
    {2'd3, 4'd0, 32'h0,        32'd0,  8'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  src_tick = '0;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmp_timer #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #5;
    chk(tag, bus_rdata, exp);
    @(negedge clk);
  endtask

  task automatic do_run(input int n);
    src_tick = 8'hFF;
    repeat (n) @(negedge clk);
    src_tick = 8'h00;
  endtask

  task automatic do_irq(input logic exp, input string tag);
    #5;
    chk(tag, {31'b0, irq}, {31'b0, exp});
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 hard reset state
    do_rd(4'd0, 32'h0, "R13 control");
    do_rd(4'd1, 32'h0, "R13 divider");
    do_rd(4'd2, 32'h0, "R13 status");
    do_rd(4'd3, 32'h0, "R13 irq enable");
    do_rd(4'd4, 32'hFFFF, "R13 compare 1");
    do_rd(4'd5, 32'hFFFF, "R13 compare 2");
    do_rd(4'd6, 32'hFFFF, "R13 compare 3");
    do_rd(4'd9, 32'h0, "R13 counter");
    do_irq(1'b0, "R13 irq");

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  a;
      logic [31:0] d, e;
      string tag;
      op = VEC[i][77:76]; a = VEC[i][75:72]; d = VEC[i][71:40]; e = VEC[i][39:8];
      tag = $sformatf("R%0d vec %0d", VEC[i][7:0], i);
      case (op)
        2'd0: do_wr(a, d);
        2'd1: do_rd(a, e, tag);
        2'd2: do_run(int'(d));
        default: do_irq(e[0], tag);
      endcase
    end

    // R11 dropped control bits, R12 soft reset
    do_wr(4'd1, 32'h5);
    do_wr(4'd3, 32'h3F);
    do_wr(4'd0, 32'hFFFF7FFF);
    do_rd(4'd0, 32'hFFFF03EB, "R11 control mask");
    do_wr(4'd0, 32'hFFFFFFFF);
    do_rd(4'd0, 32'h000001EB, "R12 kept control bits");
    do_rd(4'd4, 32'hFFFF, "R12 compare 1");
    do_rd(4'd6, 32'hFFFF, "R12 compare 3");
    do_rd(4'd1, 32'h0, "R12 divider");
    do_rd(4'd3, 32'h0, "R12 irq enable");
    do_rd(4'd2, 32'h0, "R12 status");
    do_rd(4'd9, 32'h0, "R12 counter");
    // R1 capture and unmapped addresses
    do_rd(4'd7, 32'h0, "R1 capture 1");
    do_rd(4'd8, 32'h0, "R1 capture 2");
    do_rd(4'd12, 32'h0, "R1 unmapped");

    // R7 full-range wrap in free-running mode
    do_wr(4'd0, 32'h241);
    do_run((1 << CW) - 1);
    do_rd(4'd9, 32'hFFFF, "R7 counter at top");
    do_rd(4'd2, 32'h07, "R8 all compares at top");
    do_run(1);
    do_rd(4'd9, 32'h0, "R7 wrapped");
    do_rd(4'd2, 32'h27, "R7 rollover flag");

    // R13 hard reset during operation
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_rd(4'd0, 32'h0, "R13 control after reset");
    do_rd(4'd5, 32'hFFFF, "R13 compare 2 after reset");
    do_rd(4'd2, 32'h0, "R13 status after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule